// File: doc/BRIEF.md
# Merging Write Buffer

This block sits between a write-through cache and the next memory level and holds stores until memory can take them. Every store names one data word. Stores that fall in the same aligned block share a single entry: each word slot of that entry has its own valid bit, so a run of stores to neighbouring words takes one entry and one memory transfer instead of one entry per store.

Entries leave in arrival order over a valid/ready drain port that carries the block address, all word slots and the per-word valid mask. The oldest entry is the one on offer, and it is locked against further merging so that its payload cannot change while memory holds it off. A lookup port compares a block address against every buffered entry, so that a read miss can go ahead of the queued stores while still noticing when one of them holds newer data for the block it wants.

With the default parameters the buffer has four entries of four 32-bit words, so a block is 16 bytes and byte address bits [3:2] select the word.

Top module: `mwb_top`

## Requirements
- R1: After reset `drain_valid` is 0, `wr_ready` is 1 and `probe_hit` is 0.
- R2: An accepted write whose block matches no unlocked entry takes a new entry. The block address is `wr_addr` with bits [3:0] cleared. Only the mask bit selected by `wr_addr[3:2]` is set, and the other word slots read as zero.
- R3: An accepted write whose block matches a buffered entry other than the oldest is merged into that entry. It sets its word's mask bit and stores its data. Four writes to the four words of one such block leave one entry with mask 4'b1111.
- R4: A write to a word that is already valid in an entry replaces that word's data, and the mask is unchanged.
- R5: The oldest entry is locked. A write to its block allocates a new entry and leaves the oldest entry's payload unchanged.
- R6: `drain_valid` is 1 whenever an entry is buffered. Entries are offered oldest first. `drain_data` carries word i at bits [32*i+31:32*i] and `drain_mask` bit i flags word i. While `drain_valid` is 1 and `drain_ready` is 0, the address, data and mask hold steady.
- R7: With four entries buffered, `wr_ready` is 0 for a write that matches no unlocked entry and 1 for a write that does. After a drain handshake, `wr_ready` returns to 1 on the next cycle.
- R8: `probe_hit` is 1 in the same cycle when the block of `probe_addr` (bits [31:4]) equals the block of a buffered entry, and 0 otherwise. Bits [3:0] of `probe_addr` are ignored.
- R9: A write presented while `wr_ready` is 0 is dropped and never appears on the drain port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Store request from the cache |
| wr_ready | output | 1 | Store can be taken this cycle |
| wr_addr | input | 32 | Byte address of the store (word aligned) |
| wr_data | input | 32 | Store data word |
| drain_valid | output | 1 | Oldest entry is on offer to memory |
| drain_ready | input | 1 | Memory takes the offered entry |
| drain_addr | output | 32 | Block-aligned address of the offered entry |
| drain_data | output | 128 | Word slots of the offered entry, word 0 lowest |
| drain_mask | output | 4 | Per-word valid bits of the offered entry |
| probe_addr | input | 32 | Address of a read miss to compare |
| probe_hit | output | 1 | A buffered entry holds the probed block |

## Verification
The assertions check on every cycle that the drain payload holds while memory stalls, that a write to the oldest entry's block never changes that entry, that at most one unlocked entry can match a write, that the offered entry always has a valid word, that a stall happens only when the buffer is full, and that the lookup never hits an empty buffer. Only the bench scenarios can show the merge outcome itself: the order in which entries leave, the exact masks and word positions after merging and overwriting, that a stalled write is lost, and that the lookup ignores the word offset.

// File: rtl/mwb_pkg.sv
package mwb_pkg;

    localparam int unsigned MWB_DEF_ENTRIES = 4;
    localparam int unsigned MWB_DEF_WORDS   = 4;
    localparam int unsigned MWB_DEF_ADDR_W  = 32;
    localparam int unsigned MWB_DEF_DATA_W  = 32;

    // What the write side does in the current cycle
    typedef enum logic [1:0] {
        WR_IDLE  = 2'd0,
        WR_MERGE = 2'd1,
        WR_ALLOC = 2'd2,
        WR_STALL = 2'd3
    } wr_act_e;

endpackage

// File: rtl/mwb_blk_match.sv
// One entry's block comparator: a merge candidate for the write side and a
// hit for the lookup side.
module mwb_blk_match #(
    parameter int unsigned BLK_W = 28,
    parameter int unsigned WORDS = 4
) (
    input  logic [WORDS-1:0] ent_mask,
    input  logic             ent_locked,
    input  logic [BLK_W-1:0] ent_blk,
    input  logic [BLK_W-1:0] wr_blk,
    input  logic [BLK_W-1:0] probe_blk,
    output logic             merge_hit,
    output logic             probe_hit
);

    logic ent_live;

    assign ent_live  = |ent_mask;
    assign merge_hit = ent_live && !ent_locked && (ent_blk == wr_blk);
    assign probe_hit = ent_live && (ent_blk == probe_blk);

endmodule

// File: rtl/mwb_ptr.sv
// Circular head/tail pointers and fill count of the entry queue.
module mwb_ptr #(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned IDX_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic [CNT_W-1:0] count
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    typedef struct packed {
        logic [IDX_W-1:0] head;
        logic [IDX_W-1:0] tail;
        logic [CNT_W-1:0] cnt;
    } ptr_t;

    ptr_t ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (push) begin
            ptr_d.tail = (ptr_q.tail == LAST) ? '0 : ptr_q.tail + 1'b1;
        end
        if (pop) begin
            ptr_d.head = (ptr_q.head == LAST) ? '0 : ptr_q.head + 1'b1;
        end
        ptr_d.cnt = ptr_q.cnt + CNT_W'(push) - CNT_W'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign head  = ptr_q.head;
    assign tail  = ptr_q.tail;
    assign count = ptr_q.cnt;

endmodule

// File: rtl/mwb_top.sv
// Merging write buffer: word stores in, whole masked blocks out, oldest first.
module mwb_top
    import mwb_pkg::*;
#(
    parameter int unsigned NUM_ENT = MWB_DEF_ENTRIES,
    parameter int unsigned WORDS   = MWB_DEF_WORDS,
    parameter int unsigned ADDR_W  = MWB_DEF_ADDR_W,
    parameter int unsigned DATA_W  = MWB_DEF_DATA_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_valid,
    output logic                    wr_ready,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    output logic                    drain_valid,
    input  logic                    drain_ready,
    output logic [ADDR_W-1:0]       drain_addr,
    output logic [WORDS*DATA_W-1:0] drain_data,
    output logic [WORDS-1:0]        drain_mask,
    input  logic [ADDR_W-1:0]       probe_addr,
    output logic                    probe_hit
);

    localparam int unsigned WB_W  = $clog2(DATA_W / 8);
    localparam int unsigned WI_W  = $clog2(WORDS);
    localparam int unsigned OFF_W = WB_W + WI_W;
    localparam int unsigned BLK_W = ADDR_W - OFF_W;
    localparam int unsigned IDX_W = $clog2(NUM_ENT);
    localparam int unsigned CNT_W = $clog2(NUM_ENT + 1);

    typedef struct packed {
        logic [NUM_ENT-1:0][BLK_W-1:0]             blk;
        logic [NUM_ENT-1:0][WORDS-1:0]             mask;
        logic [NUM_ENT-1:0][WORDS-1:0][DATA_W-1:0] data;
    } buf_t;

    buf_t st_d, st_q;

    logic [IDX_W-1:0]   head, tail, wr_idx, merge_idx;
    logic [CNT_W-1:0]   fill_cnt;
    logic [NUM_ENT-1:0] lock_vec, merge_vec, probe_vec;
    logic [BLK_W-1:0]   wr_blk, probe_blk;
    logic [WI_W-1:0]    wr_word;
    logic               merge_any, full, push, pop;
    wr_act_e            act;

    logic unused_offsets;
    assign unused_offsets = ^{wr_addr[WB_W-1:0], probe_addr[OFF_W-1:0]};

    assign wr_blk    = wr_addr[ADDR_W-1:OFF_W];
    assign wr_word   = wr_addr[OFF_W-1:WB_W];
    assign probe_blk = probe_addr[ADDR_W-1:OFF_W];

    // Per-entry comparators; the oldest entry is locked against merging
    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        assign lock_vec[g] = (head == IDX_W'(g));
        mwb_blk_match #(
            .BLK_W (BLK_W),
            .WORDS (WORDS)
        ) u_cmp (
            .ent_mask   (st_q.mask[g]),
            .ent_locked (lock_vec[g]),
            .ent_blk    (st_q.blk[g]),
            .wr_blk     (wr_blk),
            .probe_blk  (probe_blk),
            .merge_hit  (merge_vec[g]),
            .probe_hit  (probe_vec[g])
        );
    end

    always_comb begin
        merge_idx = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (merge_vec[i]) begin
                merge_idx = IDX_W'(i);
            end
        end
    end

    assign merge_any   = |merge_vec;
    assign full        = (fill_cnt == CNT_W'(NUM_ENT));
    assign wr_ready    = merge_any || !full;
    assign drain_valid = (fill_cnt != '0);
    assign pop         = drain_valid && drain_ready;

    always_comb begin
        if (!wr_valid)      act = WR_IDLE;
        else if (merge_any) act = WR_MERGE;
        else if (!full)     act = WR_ALLOC;
        else                act = WR_STALL;
    end

    assign push   = (act == WR_ALLOC);
    assign wr_idx = (act == WR_MERGE) ? merge_idx : tail;

    mwb_ptr #(
        .DEPTH (NUM_ENT)
    ) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .head  (head),
        .tail  (tail),
        .count (fill_cnt)
    );

    // Next state of the entry storage
    always_comb begin
        st_d = st_q;
        if (pop) begin
            st_d.mask[head] = '0;
        end
        case (act)
            WR_ALLOC: begin
                st_d.blk[wr_idx]           = wr_blk;
                st_d.mask[wr_idx]          = '0;
                st_d.data[wr_idx]          = '0;
                st_d.mask[wr_idx][wr_word] = 1'b1;
                st_d.data[wr_idx][wr_word] = wr_data;
            end
            WR_MERGE: begin
                st_d.mask[wr_idx][wr_word] = 1'b1;
                st_d.data[wr_idx][wr_word] = wr_data;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign drain_addr = {st_q.blk[head], {OFF_W{1'b0}}};
    assign drain_data = st_q.data[head];
    assign drain_mask = st_q.mask[head];
    assign probe_hit  = |probe_vec;

endmodule

// File: rtl/mwb_checker.sv
module mwb_checker #(
    parameter int unsigned NUM_ENT = 4,
    parameter int unsigned WORDS   = 4,
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned DATA_W  = 32,
    localparam int unsigned OFF_W  = $clog2(DATA_W / 8) + $clog2(WORDS),
    localparam int unsigned CNT_W  = $clog2(NUM_ENT + 1)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_valid,
    input logic                    wr_ready,
    input logic [ADDR_W-1:0]       wr_addr,
    input logic                    drain_valid,
    input logic                    drain_ready,
    input logic [ADDR_W-1:0]       drain_addr,
    input logic [WORDS*DATA_W-1:0] drain_data,
    input logic [WORDS-1:0]        drain_mask,
    input logic                    probe_hit,
    input logic [CNT_W-1:0]        fill_cnt,
    input logic [NUM_ENT-1:0]      merge_vec
);

    AST_PAYLOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_valid && !drain_ready) |=> (drain_valid && $stable(drain_addr)
            && $stable(drain_data) && $stable(drain_mask))); // R6

    AST_HEAD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_valid && !drain_ready && wr_valid && wr_ready
            && (wr_addr[ADDR_W-1:OFF_W] == drain_addr[ADDR_W-1:OFF_W]))
        |=> ($stable(drain_mask) && $stable(drain_data))); // R5

    AST_ONE_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(merge_vec)); // R3

    AST_OFFER_HAS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        drain_valid |-> (drain_mask != '0)); // R2

    AST_STALL_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ready |-> (fill_cnt == CNT_W'(NUM_ENT))); // R7

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt <= CNT_W'(NUM_ENT)); // R7

    AST_PROBE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_cnt == '0) |-> !probe_hit); // R8

endmodule

bind mwb_top mwb_checker #(
    .NUM_ENT (NUM_ENT),
    .WORDS   (WORDS),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
) u_mwb_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .wr_ready    (wr_ready),
    .wr_addr     (wr_addr),
    .drain_valid (drain_valid),
    .drain_ready (drain_ready),
    .drain_addr  (drain_addr),
    .drain_data  (drain_data),
    .drain_mask  (drain_mask),
    .probe_hit   (probe_hit),
    .fill_cnt    (fill_cnt),
    .merge_vec   (merge_vec)
);

// File: tb/tb_mwb_top.sv
`timescale 1ns/1ps
module tb_mwb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_valid = 1'b0;
    logic         wr_ready;
    logic [31:0]  wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic         drain_valid;
    logic         drain_ready = 1'b0;
    logic [31:0]  drain_addr;
    logic [127:0] drain_data;
    logic [3:0]   drain_mask;
    logic [31:0]  probe_addr = '0;
    logic         probe_hit;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    mwb_top dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_valid    (wr_valid),
        .wr_ready    (wr_ready),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .drain_valid (drain_valid),
        .drain_ready (drain_ready),
        .drain_addr  (drain_addr),
        .drain_data  (drain_data),
        .drain_mask  (drain_mask),
        .probe_addr  (probe_addr),
        .probe_hit   (probe_hit)
    );

    task automatic check(input bit ok, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    // One-cycle store; the caller decides whether it should be taken
    task automatic put(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_addr  = a;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    // Check the offered entry, then take it with a one-cycle ready pulse
    task automatic take(input logic [31:0] ea, input logic [3:0] em,
                        input logic [127:0] ed, input string tag);
        check(drain_valid == 1'b1, {tag, " drain_valid"}, 128'(drain_valid), 128'd1);
        check(drain_addr == ea, {tag, " drain_addr"}, 128'(drain_addr), 128'(ea));
        check(drain_mask == em, {tag, " drain_mask"}, 128'(drain_mask), 128'(em));
        check(drain_data == ed, {tag, " drain_data"}, drain_data, ed);
        drain_ready = 1'b1;
        @(negedge clk);
        drain_ready = 1'b0;
    endtask

    task automatic t_reset();
        check(drain_valid == 1'b0, "R1 drain_valid", 128'(drain_valid), 128'd0);
        check(wr_ready == 1'b1, "R1 wr_ready", 128'(wr_ready), 128'd1);
        check(probe_hit == 1'b0, "R1 probe_hit", 128'(probe_hit), 128'd0);
    endtask

    task automatic t_merge_four();
        put(32'h400, 32'hA0);                 // becomes the locked oldest entry
        put(32'h100, 32'h11);
        put(32'h104, 32'h22);
        put(32'h108, 32'h33);
        put(32'h10C, 32'h44);
        take(32'h400, 4'b0001, 128'hA0, "R2 alloc single word");
        take(32'h100, 4'b1111, {32'h44, 32'h33, 32'h22, 32'h11}, "R3 four words merged R6 order");
        check(drain_valid == 1'b0, "R3 one entry only", 128'(drain_valid), 128'd0);
    endtask

    task automatic t_overwrite();
        put(32'h600, 32'h1);
        put(32'h208, 32'hDEAD);
        put(32'h208, 32'hBEEF);
        take(32'h600, 4'b0001, 128'h1, "R4 head");
        take(32'h200, 4'b0100, {32'h0, 32'hBEEF, 32'h0, 32'h0}, "R4 overwrite");
        check(drain_valid == 1'b0, "R4 no extra entry", 128'(drain_valid), 128'd0);
    endtask

    task automatic t_lock();
        put(32'h300, 32'h5);
        put(32'h304, 32'h6);                  // head block is locked
        take(32'h300, 4'b0001, 128'h5, "R5 head unchanged");
        take(32'h300, 4'b0010, {32'h0, 32'h0, 32'h6, 32'h0}, "R5 new entry");
        check(drain_valid == 1'b0, "R5 empty", 128'(drain_valid), 128'd0);
    endtask

    task automatic t_full();
        logic [31:0]  a_hold;
        logic [127:0] d_hold;
        put(32'h1000, 32'h10);
        put(32'h2000, 32'h20);
        put(32'h3000, 32'h30);
        put(32'h4000, 32'h40);
        // New block while full: not ready, store dropped
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = 32'h5000; wr_data = 32'h50;
        #1;
        check(wr_ready == 1'b0, "R7 stall when full", 128'(wr_ready), 128'd0);
        @(negedge clk);
        // Block of a non-oldest entry while full: ready, merged
        wr_addr = 32'h4004; wr_data = 32'h41;
        #1;
        check(wr_ready == 1'b1, "R7 merge while full", 128'(wr_ready), 128'd1);
        @(negedge clk);
        wr_valid = 1'b0;
        probe_addr = 32'h2008;
        #1;
        check(probe_hit == 1'b1, "R8 probe hit ignores offset", 128'(probe_hit), 128'd1);
        probe_addr = 32'h5000;
        #1;
        check(probe_hit == 1'b0, "R8 probe miss R9 dropped", 128'(probe_hit), 128'd0);
        // Payload holds while memory stalls
        a_hold = drain_addr;
        d_hold = drain_data;
        repeat (3) @(negedge clk);
        check(drain_addr == a_hold && drain_data == d_hold, "R6 payload hold",
              128'(drain_addr), 128'(a_hold));
        take(32'h1000, 4'b0001, 128'h10, "R6 first");
        wr_addr = 32'h6000;
        #1;
        check(wr_ready == 1'b1, "R7 ready after drain", 128'(wr_ready), 128'd1);
        take(32'h2000, 4'b0001, 128'h20, "R6 second");
        take(32'h3000, 4'b0001, 128'h30, "R6 third");
        take(32'h4000, 4'b0011, {32'h0, 32'h0, 32'h41, 32'h40}, "R7 merged entry");
        check(drain_valid == 1'b0, "R9 dropped store absent", 128'(drain_valid), 128'd0);
        probe_addr = 32'h2000;
        #1;
        check(probe_hit == 1'b0, "R8 miss after drain", 128'(probe_hit), 128'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_merge_four();
        t_overwrite();
        t_lock();
        t_full();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule